// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier and Power-Table Generator

This block does arithmetic in the 4096-element field used by a Reed-Solomon code with 12-bit symbols. The field is not built from a single degree-12 polynomial. It is built as a quadratic extension of GF(64). Each 12-bit symbol holds two GF(64) digits. The upper six bits are the high digit and the lower six bits are the low digit. A combinational multiplier on the `mul_a`/`mul_b` ports returns their field product on `mul_p` in the same cycle.

Beside the multiplier sits a sequential power generator. After `gen_start`, the generator takes one step on each clock in which `gen_en` is high. Each step multiplies the current element by a fixed step constant, 0xE01 by default. A current value of zero counts as the seed and yields 1. Each step emits one write, and that write feeds two tables at once. The exponent port writes the new element at the step index. The log port writes the step index at the element's address. The two tables are held in memories outside the block, so the write ports map directly onto block RAM. A done flag is raised once all 4095 nonzero elements have been produced. An error flag is raised if the sequence returns to 1 early, which means the step constant is not primitive.

Top module: `gf4k_tower_unit`

## Requirements
- R1: When both operands have a zero high digit, the product equals the GF(64) product of the low digits, placed in bits 5:0. That product uses x^6+x+1: a carry into bit 6 during shift-and-add is cancelled by XOR with 0x43. For example, 0x020 times 0x002 gives 0x003.
- R2: For operands a = {ah,al} and b = {bh,bl}, the product's high digit is (ah^al)·(bh^bl) XOR al·bl. Its low digit is ah·bh·0x21 XOR al·bl. All products here are GF(64) products. For example, 0x040 times 0x040 gives 0x061.
- R3: The value 0x001 is the multiplicative identity and 0 annihilates. The product is commutative.
- R4: `mul_p` is combinational and follows `mul_a` and `mul_b` with no clock cycle of delay.
- R5: After the clock edge that samples `gen_start` high, `gen_done`, `gen_err` and `tbl_we` are low and the step index is 0. The first later step writes element 0x001 at exponent address 0. `gen_start` takes priority over `gen_en`.
- R6: At step i, which produces element e, `tbl_we` is high for one cycle after that clock edge. In that cycle `exp_addr`=i, `exp_data`=e, `log_addr`=e and `log_data`=i.
- R7: An edge with `gen_en` low takes no step. It produces no write and leaves the index and element unchanged, so the next step continues the sequence.
- R8: Each element is the previous element multiplied by the step constant 0xE01.
- R9: With the default constant, 4095 steps write 4095 distinct nonzero elements. `gen_done` rises together with the write at address 4094. After that there are no further writes and `gen_err` stays low.
- R10: If a step other than step 0 would produce 0x001, that step writes nothing. `gen_err` is then set and the generator halts with `gen_done` low.
- R11: During and right after reset, `tbl_we`, `gen_done`, `gen_err` and all table address and data outputs are 0.
- R12: `gen_done` and `gen_err` stay set until the next `gen_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mul_a | input | 12 | Multiplier operand A |
| mul_b | input | 12 | Multiplier operand B |
| mul_p | output | 12 | Combinational product A·B |
| gen_start | input | 1 | Restart the power sequence |
| gen_en | input | 1 | Take one step on this clock |
| tbl_we | output | 1 | Write strobe shared by both tables |
| exp_addr | output | 12 | Exponent table address (step index) |
| exp_data | output | 12 | Exponent table data (element) |
| log_addr | output | 12 | Log table address (element) |
| log_data | output | 12 | Log table data (step index) |
| gen_done | output | 1 | All nonzero elements produced |
| gen_err | output | 1 | Sequence returned to 1 early |

## Verification
A bad subfield reduction or a bad composition term shows on `mul_p` as soon as the operands settle. The same fault also shows in the first generator write that depends on it. A corrupted element register spoils every later `exp_data` and `log_addr` from the next write on. It also usually breaks distinctness long before done. A wrong index register shows at once in `exp_addr` and `log_data`. A wrong terminal count moves the `gen_done` edge off the write at address 4094. The early-return detector is driven with a non-primitive constant, the identity. With that constant the error must appear on the second step, with that step's write suppressed.

// File: rtl/gf4k_pkg.sv
package gf4k_pkg;

  // Generator control states
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_RUN  = 2'd1,
    GS_DONE = 2'd2,
    GS_FAIL = 2'd3
  } gen_state_e;

  // Default field shape: 12-bit symbol over a 6-bit subfield
  localparam int unsigned DEF_SYM_W      = 12;
  localparam logic [6:0]  DEF_HALF_POLY  = 7'h43;   // x^6 + x + 1
  localparam logic [5:0]  DEF_HALF_KAPPA = 6'h21;   // inverse of subfield generator
  localparam logic [11:0] DEF_STEP_CONST = 12'hE01; // primitive step element

endpackage

// File: rtl/gf_sub_mul.sv
// Shift-and-add multiplier in the GF(2^W) subfield.
module gf_sub_mul #(
  parameter int unsigned W    = 6,
  parameter logic [W:0]  POLY = 7'h43
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p
);

  logic [W-1:0] bsh [W];    // b·x^k, reduced
  logic [W-1:0] acc [W+1];  // running partial sums

  assign bsh[0] = b;
  assign acc[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    assign acc[k+1] = acc[k] ^ (a[k] ? bsh[k] : '0);
    if (k < W - 1) begin : g_shift
      logic [W:0] sh;
      assign sh       = {bsh[k], 1'b0};
      assign bsh[k+1] = sh[W-1:0] ^ (sh[W] ? POLY[W-1:0] : '0);
    end
  end

  assign p = acc[W];

endmodule

// File: rtl/gf_tower_mul.sv
// Quadratic-extension multiplier: symbol = {hi, lo} over the subfield.
module gf_tower_mul #(
  parameter int unsigned         SYM_W      = 12,
  parameter logic [SYM_W/2:0]    HALF_POLY  = 7'h43,
  parameter logic [SYM_W/2-1:0]  HALF_KAPPA = 6'h21
) (
  input  logic [SYM_W-1:0] a,
  input  logic [SYM_W-1:0] b,
  output logic [SYM_W-1:0] p
);

  localparam int unsigned HW = SYM_W / 2;

  logic [HW-1:0] ah, al, bh, bl;
  logic [HW-1:0] p_lo, p_sum, p_hi, p_hk;

  assign ah = a[SYM_W-1:HW];
  assign al = a[HW-1:0];
  assign bh = b[SYM_W-1:HW];
  assign bl = b[HW-1:0];

  gf_sub_mul #(.W(HW), .POLY(HALF_POLY)) u_lo (
    .a(al), .b(bl), .p(p_lo)
  );

  gf_sub_mul #(.W(HW), .POLY(HALF_POLY)) u_sum (
    .a(ah ^ al), .b(bh ^ bl), .p(p_sum)
  );

  gf_sub_mul #(.W(HW), .POLY(HALF_POLY)) u_hi (
    .a(ah), .b(bh), .p(p_hi)
  );

  gf_sub_mul #(.W(HW), .POLY(HALF_POLY)) u_kappa (
    .a(p_hi), .b(HALF_KAPPA), .p(p_hk)
  );

  assign p = {p_sum ^ p_lo, p_hk ^ p_lo};

endmodule

// File: rtl/gf_pow_seq.sv
// Steps through powers of the step constant and emits exp/log table writes.
module gf_pow_seq
  import gf4k_pkg::*;
#(
  parameter int unsigned         SYM_W      = 12,
  parameter logic [SYM_W/2:0]    HALF_POLY  = 7'h43,
  parameter logic [SYM_W/2-1:0]  HALF_KAPPA = 6'h21,
  parameter logic [SYM_W-1:0]    STEP_CONST = 12'hE01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             en,
  output logic             we,
  output logic [SYM_W-1:0] exp_addr,
  output logic [SYM_W-1:0] exp_data,
  output logic [SYM_W-1:0] log_addr,
  output logic [SYM_W-1:0] log_data,
  output logic             done,
  output logic             err
);

  localparam int unsigned     N_STEPS = (1 << SYM_W) - 1;
  localparam logic [SYM_W-1:0] LAST_IDX = SYM_W'(N_STEPS - 1);
  localparam logic [SYM_W-1:0] ONE      = SYM_W'(1);

  gen_state_e       state;
  logic [SYM_W-1:0] cur;
  logic [SYM_W-1:0] idx;
  logic [SYM_W-1:0] prod;
  logic [SYM_W-1:0] nxt;
  logic             wrap_early;

  gf_tower_mul #(
    .SYM_W(SYM_W), .HALF_POLY(HALF_POLY), .HALF_KAPPA(HALF_KAPPA)
  ) u_step_mul (
    .a(cur), .b(STEP_CONST), .p(prod)
  );

  assign nxt        = (cur == '0) ? ONE : prod;
  assign wrap_early = (nxt == ONE) && (idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= GS_IDLE;
      cur      <= '0;
      idx      <= '0;
      we       <= 1'b0;
      exp_addr <= '0;
      exp_data <= '0;
      log_addr <= '0;
      log_data <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start) begin
        state <= GS_RUN;
        cur   <= '0;
        idx   <= '0;
        done  <= 1'b0;
        err   <= 1'b0;
      end else if (state == GS_RUN && en) begin
        if (wrap_early) begin
          state <= GS_FAIL;
          err   <= 1'b1;
        end else begin
          we       <= 1'b1;
          exp_addr <= idx;
          exp_data <= nxt;
          log_addr <= nxt;
          log_data <= idx;
          cur      <= nxt;
          idx      <= idx + 1'b1;
          if (idx == LAST_IDX) begin
            state <= GS_DONE;
            done  <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/gf4k_tower_unit.sv
module gf4k_tower_unit
  import gf4k_pkg::*;
#(
  parameter int unsigned         SYM_W      = DEF_SYM_W,
  parameter logic [SYM_W/2:0]    HALF_POLY  = DEF_HALF_POLY,
  parameter logic [SYM_W/2-1:0]  HALF_KAPPA = DEF_HALF_KAPPA,
  parameter logic [SYM_W-1:0]    STEP_CONST = DEF_STEP_CONST
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] mul_a,
  input  logic [SYM_W-1:0] mul_b,
  output logic [SYM_W-1:0] mul_p,
  input  logic             gen_start,
  input  logic             gen_en,
  output logic             tbl_we,
  output logic [SYM_W-1:0] exp_addr,
  output logic [SYM_W-1:0] exp_data,
  output logic [SYM_W-1:0] log_addr,
  output logic [SYM_W-1:0] log_data,
  output logic             gen_done,
  output logic             gen_err
);

  gf_tower_mul #(
    .SYM_W(SYM_W), .HALF_POLY(HALF_POLY), .HALF_KAPPA(HALF_KAPPA)
  ) u_port_mul (
    .a(mul_a), .b(mul_b), .p(mul_p)
  );

  gf_pow_seq #(
    .SYM_W(SYM_W), .HALF_POLY(HALF_POLY), .HALF_KAPPA(HALF_KAPPA),
    .STEP_CONST(STEP_CONST)
  ) u_seq (
    .clk(clk), .rst(rst), .start(gen_start), .en(gen_en),
    .we(tbl_we), .exp_addr(exp_addr), .exp_data(exp_data),
    .log_addr(log_addr), .log_data(log_data),
    .done(gen_done), .err(gen_err)
  );

endmodule

// File: rtl/gf4k_tower_unit_chk.sv
module gf4k_tower_unit_chk #(
  parameter int unsigned SYM_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [SYM_W-1:0] mul_a,
  input logic [SYM_W-1:0] mul_b,
  input logic [SYM_W-1:0] mul_p,
  input logic             gen_start,
  input logic             gen_en,
  input logic             tbl_we,
  input logic [SYM_W-1:0] exp_addr,
  input logic [SYM_W-1:0] exp_data,
  input logic             gen_done,
  input logic             gen_err
);

  localparam logic [SYM_W-1:0] LAST_ADDR = SYM_W'((1 << SYM_W) - 2);
  localparam logic [SYM_W-1:0] ONE       = SYM_W'(1);

  AST_MUL_IDENTITY: assert property (@(posedge clk) disable iff (rst) (mul_b == ONE) |-> (mul_p == mul_a)); // R3
  AST_MUL_ZERO: assert property (@(posedge clk) disable iff (rst) (mul_a == '0 || mul_b == '0) |-> (mul_p == '0)); // R3
  AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) tbl_we |-> ($past(gen_en) && !$past(gen_start))); // R7
  AST_FIRST_IS_ONE: assert property (@(posedge clk) disable iff (rst) (tbl_we && exp_addr == '0) |-> (exp_data == ONE)); // R5
  AST_TABLE_NONZERO: assert property (@(posedge clk) disable iff (rst) tbl_we |-> (exp_data != '0)); // R6
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst) $rose(gen_done) |-> (tbl_we && exp_addr == LAST_ADDR)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(gen_done && gen_err)); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) (gen_done && !gen_start) |=> gen_done); // R12
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst) (gen_err && !gen_start) |=> (gen_err && !tbl_we)); // R10

endmodule

bind gf4k_tower_unit gf4k_tower_unit_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
  .gen_start(gen_start), .gen_en(gen_en), .tbl_we(tbl_we),
  .exp_addr(exp_addr), .exp_data(exp_data),
  .gen_done(gen_done), .gen_err(gen_err)
);

// File: tb/gf4k_tower_unit_tb.sv
`timescale 1ns/1ps
module gf4k_tower_unit_tb;

  localparam int N_ELEM = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic [11:0] mul_a = '0, mul_b = '0, mul_p;
  logic        gen_start = 1'b0, gen_en = 1'b0;
  logic        tbl_we, gen_done, gen_err;
  logic [11:0] exp_addr, exp_data, log_addr, log_data;

  logic        l_start = 1'b0, l_en = 1'b0;
  logic        l_we, l_done, l_err;
  logic [11:0] l_ea, l_ed, l_la, l_ld, l_p;

  gf4k_tower_unit u_dut (
    .clk(clk), .rst(rst), .mul_a(mul_a), .mul_b(mul_b), .mul_p(mul_p),
    .gen_start(gen_start), .gen_en(gen_en), .tbl_we(tbl_we),
    .exp_addr(exp_addr), .exp_data(exp_data),
    .log_addr(log_addr), .log_data(log_data),
    .gen_done(gen_done), .gen_err(gen_err)
  );

  // Identity as step constant: not primitive, must trip the early-return check
  gf4k_tower_unit #(.STEP_CONST(12'h001)) u_dut_loop (
    .clk(clk), .rst(rst), .mul_a(12'h000), .mul_b(12'h000), .mul_p(l_p),
    .gen_start(l_start), .gen_en(l_en), .tbl_we(l_we),
    .exp_addr(l_ea), .exp_data(l_ed), .log_addr(l_la), .log_data(l_ld),
    .gen_done(l_done), .gen_err(l_err)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [5:0] m64(input logic [5:0] x, input logic [5:0] y);
    logic [6:0] t;
    logic [5:0] r;
    r = '0;
    t = {1'b0, y};
    for (int i = 0; i < 6; i++) begin
      if (x[i]) r ^= t[5:0];
      t = t << 1;
      if (t[6]) t ^= 7'h43;
    end
    return r;
  endfunction

  function automatic logic [11:0] m4k(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] hi, lo;
    lo = m64(m64(a[11:6], b[11:6]), 6'h21) ^ m64(a[5:0], b[5:0]);
    hi = m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ m64(a[5:0], b[5:0]);
    return {hi, lo};
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R11 we", tbl_we, 0);
    chk("R11 done", gen_done, 0);
    chk("R11 err", gen_err, 0);
    chk("R11 exp_addr", exp_addr, 0);
    chk("R11 log_data", log_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 we after release", tbl_we, 0);
    chk("R11 done after release", gen_done, 0);
  endtask

  task automatic t_mul_subfield();
    mul_a = 12'h020; mul_b = 12'h002; #1;
    chk("R1 x^5*x", mul_p, 12'h003);
    mul_a = 12'h03F; mul_b = 12'h03F; #1;
    chk("R1 low-only", mul_p, {6'h00, m64(6'h3F, 6'h3F)});
    mul_a = 12'h021; mul_b = 12'h020; #1;
    chk("R1 low-only 2", mul_p, {6'h00, m64(6'h21, 6'h20)});
  endtask

  task automatic t_mul_tower();
    logic [11:0] lf;
    mul_a = 12'h040; mul_b = 12'h040; #1;
    chk("R2 hi*hi", mul_p, 12'h061);
    lf = 12'hACE;
    for (int i = 0; i < 40; i++) begin
      mul_a = lf;
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
      mul_b = lf;
      #1;
      chk("R2 random", mul_p, m4k(mul_a, mul_b));
      lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
    end
  endtask

  task automatic t_mul_identity();
    logic [11:0] ab;
    mul_a = 12'hE01; mul_b = 12'h001; #1;
    chk("R3 identity", mul_p, 12'hE01);
    mul_a = 12'h5A3; mul_b = 12'h000; #1;
    chk("R3 zero", mul_p, 12'h000);
    mul_a = 12'h7C4; mul_b = 12'h1B9; #1;
    ab = mul_p;
    mul_a = 12'h1B9; mul_b = 12'h7C4; #1;
    chk("R3 commute", mul_p, ab);
    // R4: result present in the same cycle, before any clock edge
    @(negedge clk);
    mul_a = 12'h123; mul_b = 12'h456; #2;
    chk("R4 same-cycle", mul_p, m4k(12'h123, 12'h456));
  endtask

  task automatic t_gen_full();
    logic [11:0] e;
    bit seen [4096];
    int errs;
    errs = 0;
    e = '0;
    for (int k = 0; k < 4096; k++) seen[k] = 0;
    @(negedge clk); gen_start = 1'b1; gen_en = 1'b1;
    @(negedge clk);
    chk("R5 no write on start", tbl_we, 0);
    gen_start = 1'b0;
    for (int i = 0; i < N_ELEM; i++) begin
      if (i == 100) begin
        gen_en = 1'b0;
        for (int j = 0; j < 3; j++) begin
          @(negedge clk);
          chk("R7 paused no write", tbl_we, 0);
        end
        gen_en = 1'b1;
      end
      @(negedge clk);
      e = (e == 12'h000) ? 12'h001 : m4k(e, 12'hE01);
      if (i == 0) chk("R5 first element", exp_data, 12'h001);
      if (i == 101) chk("R7 resumes at index", exp_addr, 12'(i));
      if (tbl_we !== 1'b1 || exp_addr !== 12'(i) || exp_data !== e ||
          log_addr !== e || log_data !== 12'(i)) begin
        errs++;
        if (errs < 5)
          $display("FAIL R6/R8 step %0d: we=%0b ea=0x%0h ed=0x%0h la=0x%0h ld=0x%0h expected ed=0x%0h",
                   i, tbl_we, exp_addr, exp_data, log_addr, log_data, e);
      end
      if (e == 12'h000 || seen[e]) begin
        errs++;
        if (errs < 5) $display("FAIL R9 step %0d: element 0x%0h repeated or zero, expected new", i, e);
      end
      seen[e] = 1;
      if (gen_done !== (i == N_ELEM - 1)) begin
        errs++;
        if (errs < 5) $display("FAIL R9 done at step %0d: actual %0b expected %0b", i, gen_done, i == N_ELEM - 1);
      end
    end
    n_vec++;
    if (errs != 0) n_bad++;
    chk("R9 last address", exp_addr, 12'hFFE);
    chk("R9 err low", gen_err, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R9 no write after done", tbl_we, 0);
      chk("R12 done held", gen_done, 1);
    end
  endtask

  task automatic t_restart();
    @(negedge clk); gen_start = 1'b1; gen_en = 1'b1;
    @(negedge clk);
    chk("R5 done cleared", gen_done, 0);
    chk("R12 cleared only by start", tbl_we, 0);
    gen_start = 1'b0;
    @(negedge clk);
    chk("R5 restart addr", exp_addr, 0);
    chk("R5 restart data", exp_data, 12'h001);
    @(negedge clk);
    chk("R8 second element", exp_data, 12'hE01);
    @(negedge clk);
    chk("R8 third element", exp_data, m4k(12'hE01, 12'hE01));
    gen_en = 1'b0;
  endtask

  task automatic t_gen_loop();
    @(negedge clk); l_start = 1'b1; l_en = 1'b1;
    @(negedge clk); l_start = 1'b0;
    @(negedge clk);
    chk("R10 first write", l_we, 1);
    chk("R10 first data", l_ed, 12'h001);
    @(negedge clk);
    chk("R10 err set", l_err, 1);
    chk("R10 repeat not written", l_we, 0);
    chk("R10 done low", l_done, 0);
    @(negedge clk); @(negedge clk);
    chk("R12 err held", l_err, 1);
    chk("R10 halted", l_we, 0);
    l_start = 1'b1;
    @(negedge clk);
    chk("R5 err cleared", l_err, 0);
    l_start = 1'b0; l_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_mul_subfield();
    t_mul_tower();
    t_mul_identity();
    t_gen_full();
    t_restart();
    t_gen_loop();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule